// File: doc/BRIEF.md
# Dimension-Reversal Escape Channel Selector

This block decides, once per hop in one router, which virtual channel a message's header takes next. Each physical link carries two classes of virtual channel. Adaptive channels may be used in any profitable direction. Deterministic escape channels are used in strict dimension order. Every header carries three fields: a dimension-reversal count, a class bit, and the dimension of the previous hop. A hop into a dimension numbered lower than the previous one is a reversal, and it raises the count.

Each adaptive channel carries a label: the count of the message that holds it. The channel state (adaptive busy flags, adaptive labels, escape busy flags) is supplied to the selector from outside, together with the set of profitable output dimensions. The selector returns four things:
- the chosen channel and its class;
- whether the message allocates that channel now or waits on it;
- the rewritten header;
- a label write for a newly allocated adaptive channel.

When an upstream unit reports that a tail flit has released a channel, the selector also issues a label clear for that channel.

The selector prefers a free adaptive channel. It may instead wait on a busy adaptive channel, but only when that channel's label is not lower than the message's own count. If neither is possible, it moves the message to the escape class, and the message never leaves it. A count that has reached its parameterized ceiling also forces the move to the escape class.

Top module: `dres_sel`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, gnt_valid, lbl_set_en and lbl_clr_en are low.
- R2: A decision appears on the outputs one clock after the request cycle. gnt_valid stays low after a cycle with req_valid low, and after a request whose cand_mask is all zero. A granted gnt_dim is always a dimension that was set in cand_mask.
- R3: out_prev equals the chosen dimension. out_dr equals hdr_dr plus one when the chosen dimension index is lower than hdr_prev; otherwise out_dr equals hdr_dr. No increment happens once hdr_dr is at or above DR_MAX.
- R4: If any candidate adaptive channel is free (ad_busy bit 0), the lowest-index free candidate is granted with gnt_esc=0 and gnt_wait=0. In the same cycle lbl_set_en is 1, lbl_set_dim is that dimension and lbl_set_val is the updated count.
- R5: If no candidate adaptive channel is free, the lowest-index candidate whose label (ad_label bits [d*DR_W +: DR_W]) is at least the count the message would carry on that channel is granted with gnt_esc=0, gnt_wait=1, and no label write.
- R6: If no candidate adaptive channel is free or waitable, the escape class is granted: gnt_esc=1, out_esc=1, gnt_dim is the lowest-index candidate, and gnt_wait equals esc_busy of that dimension.
- R7: A header with hdr_esc=1 is always granted an escape channel at the lowest-index candidate, even when free adaptive channels exist, and out_esc stays 1.
- R8: A header whose hdr_dr is at or above DR_MAX is granted an escape channel, as in R6, regardless of adaptive channel state.
- R9: A cycle with rel_valid=1 yields lbl_clr_en=1 and lbl_clr_dim equal to rel_dim one clock later, independent of any concurrent request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A header requests a channel this cycle |
| hdr_dr | input | DR_W | Incoming dimension-reversal count |
| hdr_esc | input | 1 | Incoming class bit, 1 = escape class |
| hdr_prev | input | DIM_W | Dimension of the previous hop (0 at injection) |
| cand_mask | input | NUM_DIM | Profitable output dimensions |
| ad_busy | input | NUM_DIM | Adaptive channel occupied, per dimension |
| ad_label | input | NUM_DIM*DR_W | Adaptive channel labels, field d at [d*DR_W +: DR_W] |
| esc_busy | input | NUM_DIM | Escape channel occupied, per dimension |
| rel_valid | input | 1 | A tail flit released an adaptive channel |
| rel_dim | input | DIM_W | Dimension of the released channel |
| gnt_valid | output | 1 | Decision valid |
| gnt_esc | output | 1 | Granted channel is in the escape class |
| gnt_wait | output | 1 | Message waits on the granted channel instead of taking it |
| gnt_dim | output | DIM_W | Granted dimension |
| out_dr | output | DR_W | Updated reversal count |
| out_esc | output | 1 | Updated class bit |
| out_prev | output | DIM_W | Updated previous-hop dimension |
| lbl_set_en | output | 1 | Write a label for a newly allocated adaptive channel |
| lbl_set_dim | output | DIM_W | Dimension whose label is written |
| lbl_set_val | output | DR_W | Label value |
| lbl_clr_en | output | 1 | Clear a label |
| lbl_clr_dim | output | DIM_W | Dimension whose label is cleared |

## Verification
The bench builds the selector with four dimensions, a 3-bit count and a ceiling of 3. Four dimensions let one request offer both free and busy candidates on either side of the previous dimension, so reversal and non-reversal hops share a scenario. The low ceiling lets a single hop take the count to its limit, and a following header arrive already saturated to exercise the forced escape. Labels are set just below and exactly at the updated count, which separates a forbidden wait from a permitted one.

// File: rtl/dres_pkg.sv
package dres_pkg;
   typedef enum logic [1:0] {
      PICK_NONE = 2'd0,
      PICK_FREE = 2'd1,
      PICK_WAIT = 2'd2,
      PICK_ESC  = 2'd3
   } pick_e;
endpackage

// File: rtl/dres_prio.sv
module dres_prio #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/dres_step.sv
module dres_step #(
   parameter int DR_W   = 3,
   parameter int DR_MAX = 6,
   parameter int DIM_W  = 2,
   parameter int D      = 0
) (
   input  logic [DR_W-1:0]  dr_in,
   input  logic [DIM_W-1:0] prev,
   input  logic [DR_W-1:0]  label,
   output logic [DR_W-1:0]  dr_nxt,
   output logic             may_wait
);
   localparam logic [DIM_W-1:0] MY_DIM = DIM_W'(D);
   localparam logic [DR_W-1:0]  CEIL   = DR_W'(DR_MAX);

   logic reversal;

   always_comb begin
      reversal = (MY_DIM < prev);
      dr_nxt   = (reversal && (dr_in < CEIL)) ? dr_in + DR_W'(1) : dr_in;
      may_wait = (label >= dr_nxt);
   end
endmodule

// File: rtl/dres_sel.sv
module dres_sel #(
   parameter int NUM_DIM = 3,
   parameter int DR_W    = 3,
   parameter int DR_MAX  = 6,
   localparam int DIM_W  = (NUM_DIM > 1) ? $clog2(NUM_DIM) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [DR_W-1:0]         hdr_dr,
   input  logic                    hdr_esc,
   input  logic [DIM_W-1:0]        hdr_prev,
   input  logic [NUM_DIM-1:0]      cand_mask,
   input  logic [NUM_DIM-1:0]      ad_busy,
   input  logic [NUM_DIM*DR_W-1:0] ad_label,
   input  logic [NUM_DIM-1:0]      esc_busy,
   input  logic                    rel_valid,
   input  logic [DIM_W-1:0]        rel_dim,
   output logic                    gnt_valid,
   output logic                    gnt_esc,
   output logic                    gnt_wait,
   output logic [DIM_W-1:0]        gnt_dim,
   output logic [DR_W-1:0]         out_dr,
   output logic                    out_esc,
   output logic [DIM_W-1:0]        out_prev,
   output logic                    lbl_set_en,
   output logic [DIM_W-1:0]        lbl_set_dim,
   output logic [DR_W-1:0]         lbl_set_val,
   output logic                    lbl_clr_en,
   output logic [DIM_W-1:0]        lbl_clr_dim
);
   import dres_pkg::*;

   localparam logic [DR_W-1:0] CEIL = DR_W'(DR_MAX);

   if (NUM_DIM < 2) begin : g_bad_dim
      $error("dres_sel: NUM_DIM must be at least 2");
   end
   if (DR_W < 1 || DR_MAX < 1 || DR_MAX >= (1 << DR_W)) begin : g_bad_dr
      $error("dres_sel: DR_MAX must lie in 1 .. 2**DR_W-1");
   end

   logic [DR_W-1:0]    dr_nxt [NUM_DIM];
   logic [NUM_DIM-1:0] ok_vec;

   for (genvar d = 0; d < NUM_DIM; d++) begin : g_step
      dres_step #(
         .DR_W   (DR_W),
         .DR_MAX (DR_MAX),
         .DIM_W  (DIM_W),
         .D      (d)
      ) u_step (
         .dr_in    (hdr_dr),
         .prev     (hdr_prev),
         .label    (ad_label[d*DR_W +: DR_W]),
         .dr_nxt   (dr_nxt[d]),
         .may_wait (ok_vec[d])
      );
   end

   logic [NUM_DIM-1:0] free_vec, wait_vec;
   logic               free_any, wait_any, cand_any;
   logic [DIM_W-1:0]   free_idx, wait_idx, esc_idx;

   assign free_vec = cand_mask & ~ad_busy;
   assign wait_vec = cand_mask & ad_busy & ok_vec;

   dres_prio #(.N(NUM_DIM), .IW(DIM_W)) u_free (.vec(free_vec),  .found(free_any), .idx(free_idx));
   dres_prio #(.N(NUM_DIM), .IW(DIM_W)) u_wait (.vec(wait_vec),  .found(wait_any), .idx(wait_idx));
   dres_prio #(.N(NUM_DIM), .IW(DIM_W)) u_esc  (.vec(cand_mask), .found(cand_any), .idx(esc_idx));

   pick_e            pick;
   logic [DIM_W-1:0] sel_dim;
   logic [DR_W-1:0]  sel_dr;
   logic             forced;

   always_comb begin
      forced = hdr_esc || (hdr_dr >= CEIL);
      if (!(req_valid && cand_any)) pick = PICK_NONE;
      else if (forced)              pick = PICK_ESC;
      else if (free_any)            pick = PICK_FREE;
      else if (wait_any)            pick = PICK_WAIT;
      else                          pick = PICK_ESC;

      unique case (pick)
         PICK_FREE: sel_dim = free_idx;
         PICK_WAIT: sel_dim = wait_idx;
         default:   sel_dim = esc_idx;
      endcase
      sel_dr = dr_nxt[sel_dim];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_valid   <= 1'b0;
         gnt_esc     <= 1'b0;
         gnt_wait    <= 1'b0;
         gnt_dim     <= '0;
         out_dr      <= '0;
         out_esc     <= 1'b0;
         out_prev    <= '0;
         lbl_set_en  <= 1'b0;
         lbl_set_dim <= '0;
         lbl_set_val <= '0;
         lbl_clr_en  <= 1'b0;
         lbl_clr_dim <= '0;
      end else begin
         gnt_valid   <= (pick != PICK_NONE);
         gnt_esc     <= (pick == PICK_ESC);
         gnt_wait    <= (pick == PICK_WAIT) || ((pick == PICK_ESC) && esc_busy[sel_dim]);
         gnt_dim     <= sel_dim;
         out_dr      <= sel_dr;
         out_esc     <= (pick == PICK_ESC);
         out_prev    <= sel_dim;
         lbl_set_en  <= (pick == PICK_FREE);
         lbl_set_dim <= sel_dim;
         lbl_set_val <= sel_dr;
         lbl_clr_en  <= rel_valid;
         lbl_clr_dim <= rel_dim;
      end
   end
endmodule

// File: rtl/dres_sel_chk.sv
module dres_sel_chk #(
   parameter int NUM_DIM = 3,
   parameter int DR_W    = 3,
   parameter int DR_MAX  = 6,
   localparam int DIM_W  = (NUM_DIM > 1) ? $clog2(NUM_DIM) : 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic [DR_W-1:0]         hdr_dr,
   input logic                    hdr_esc,
   input logic [DIM_W-1:0]        hdr_prev,
   input logic [NUM_DIM-1:0]      cand_mask,
   input logic [NUM_DIM-1:0]      ad_busy,
   input logic [NUM_DIM*DR_W-1:0] ad_label,
   input logic [NUM_DIM-1:0]      esc_busy,
   input logic                    rel_valid,
   input logic [DIM_W-1:0]        rel_dim,
   input logic                    gnt_valid,
   input logic                    gnt_esc,
   input logic                    gnt_wait,
   input logic [DIM_W-1:0]        gnt_dim,
   input logic [DR_W-1:0]         out_dr,
   input logic                    out_esc,
   input logic [DIM_W-1:0]        out_prev,
   input logic                    lbl_set_en,
   input logic [DIM_W-1:0]        lbl_set_dim,
   input logic [DR_W-1:0]         lbl_set_val,
   input logic                    lbl_clr_en,
   input logic [DIM_W-1:0]        lbl_clr_dim
);
   logic [NUM_DIM-1:0] cand_q;
   always_ff @(posedge clk) cand_q <= cand_mask;

   AST_ESC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && hdr_esc && (cand_mask != '0)) |=> (gnt_valid && gnt_esc && out_esc)); // R7

   AST_SAT_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (hdr_dr >= DR_W'(DR_MAX)) && (cand_mask != '0)) |=> (gnt_valid && gnt_esc)); // R8

   AST_LABEL_ON_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      lbl_set_en |-> (gnt_valid && !gnt_esc && !gnt_wait && lbl_set_dim == gnt_dim && lbl_set_val == out_dr)); // R4

   AST_DR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (cand_mask != '0)) |=> (out_dr == $past(hdr_dr) || out_dr == $past(hdr_dr) + DR_W'(1))); // R3

   AST_IN_CAND: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> cand_q[gnt_dim]); // R2

   AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && (cand_mask != '0)) |=> !gnt_valid); // R2

   AST_CLR_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |=> (lbl_clr_en && lbl_clr_dim == $past(rel_dim))); // R9
endmodule

bind dres_sel dres_sel_chk #(.NUM_DIM(NUM_DIM), .DR_W(DR_W), .DR_MAX(DR_MAX)) u_chk (.*);

// File: tb/tb_dres_sel.sv
module tb_dres_sel;
   localparam int CLK_PERIOD = 10;
   localparam int ND = 4;
   localparam int DW = 3;
   localparam int DM = 3;
   localparam int IW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [DW-1:0] hdr_dr = '0;
   logic hdr_esc = 1'b0;
   logic [IW-1:0] hdr_prev = '0;
   logic [ND-1:0] cand_mask = '0, ad_busy = '0, esc_busy = '0;
   logic [ND*DW-1:0] ad_label = '0;
   logic rel_valid = 1'b0;
   logic [IW-1:0] rel_dim = '0;
   logic gnt_valid, gnt_esc, gnt_wait, out_esc, lbl_set_en, lbl_clr_en;
   logic [IW-1:0] gnt_dim, out_prev, lbl_set_dim, lbl_clr_dim;
   logic [DW-1:0] out_dr, lbl_set_val;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dres_sel #(.NUM_DIM(ND), .DR_W(DW), .DR_MAX(DM)) dut (.*);

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Drive one request at a falling edge; outputs are registered at the next rising edge
   // and sampled at the following falling edge.
   task automatic step(input bit v, input int dr, input bit esc, input int prev,
                       input logic [ND-1:0] cand, input logic [ND-1:0] busy,
                       input logic [ND*DW-1:0] lab, input logic [ND-1:0] ebusy,
                       input bit rv, input int rd);
      req_valid = v;  hdr_dr = DW'(dr); hdr_esc = esc; hdr_prev = IW'(prev);
      cand_mask = cand; ad_busy = busy; ad_label = lab; esc_busy = ebusy;
      rel_valid = rv; rel_dim = IW'(rd);
      @(negedge clk);
      req_valid = 1'b0; rel_valid = 1'b0;
   endtask

   function automatic logic [ND*DW-1:0] labs(input int l0, input int l1, input int l2, input int l3);
      return {DW'(l3), DW'(l2), DW'(l1), DW'(l0)};
   endfunction

   task automatic t_reset();
      chk("R1 gnt_valid in reset", gnt_valid, 0);
      chk("R1 lbl_set_en in reset", lbl_set_en, 0);
      chk("R1 lbl_clr_en in reset", lbl_clr_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 gnt_valid after reset", gnt_valid, 0);
   endtask

   task automatic t_free_reversal();
      step(1, 1, 0, 2, 4'b1010, 4'b0000, labs(0,0,0,0), 4'b0000, 0, 0);
      chk("R4 free grant valid", gnt_valid, 1);
      chk("R4 free dim lowest", gnt_dim, 1);
      chk("R4 free class adaptive", gnt_esc, 0);
      chk("R4 free no wait", gnt_wait, 0);
      chk("R3 reversal increments", out_dr, 2);
      chk("R3 out_prev", out_prev, 1);
      chk("R4 label set", lbl_set_en, 1);
      chk("R4 label dim", lbl_set_dim, 1);
      chk("R4 label value", lbl_set_val, 2);
   endtask

   task automatic t_free_skip_busy();
      step(1, 0, 0, 0, 4'b1011, 4'b0011, labs(7,7,0,0), 4'b0000, 0, 0);
      chk("R4 skips busy to dim3", gnt_dim, 3);
      chk("R4 wait low", gnt_wait, 0);
      chk("R3 no reversal keeps count", out_dr, 0);
      chk("R4 label value 0", lbl_set_val, 0);
   endtask

   task automatic t_wait_label();
      // dim1: updated count 2, label 1 -> forbidden; dim2: updated 2, label 2 -> allowed
      step(1, 1, 0, 3, 4'b0110, 4'b1111, labs(0,1,2,0), 4'b0000, 0, 0);
      chk("R5 wait grant valid", gnt_valid, 1);
      chk("R5 wait dim", gnt_dim, 2);
      chk("R5 wait flag", gnt_wait, 1);
      chk("R5 wait adaptive", gnt_esc, 0);
      chk("R5 no label write", lbl_set_en, 0);
      chk("R3 wait count", out_dr, 2);
   endtask

   task automatic t_escape();
      step(1, 2, 0, 0, 4'b0101, 4'b1111, labs(1,7,1,7), 4'b0100, 0, 0);
      chk("R6 escape class", gnt_esc, 1);
      chk("R6 escape header bit", out_esc, 1);
      chk("R6 escape lowest dim", gnt_dim, 0);
      chk("R6 escape free no wait", gnt_wait, 0);
      chk("R6 escape count kept", out_dr, 2);
      chk("R6 no label write", lbl_set_en, 0);
      step(1, 2, 0, 0, 4'b0101, 4'b1111, labs(1,7,1,7), 4'b0001, 0, 0);
      chk("R6 escape busy waits", gnt_wait, 1);
   endtask

   task automatic t_sticky();
      step(1, 0, 1, 3, 4'b1100, 4'b0000, labs(0,0,0,0), 4'b0000, 0, 0);
      chk("R7 stays escape", gnt_esc, 1);
      chk("R7 header bit kept", out_esc, 1);
      chk("R7 dimension order", gnt_dim, 2);
      chk("R7 no label despite free adaptive", lbl_set_en, 0);
      chk("R3 reversal in escape", out_dr, 1);
   endtask

   task automatic t_saturation();
      step(1, 2, 0, 3, 4'b0010, 4'b0000, labs(0,0,0,0), 4'b0000, 0, 0);
      chk("R3 count reaches ceiling", out_dr, 3);
      chk("R3 hop to ceiling still adaptive", gnt_esc, 0);
      step(1, 3, 0, 3, 4'b0001, 4'b0000, labs(0,0,0,0), 4'b0000, 0, 0);
      chk("R8 saturated forces escape", gnt_esc, 1);
      chk("R8 no label", lbl_set_en, 0);
      chk("R3 saturated no increment", out_dr, 3);
   endtask

   task automatic t_idle();
      step(0, 1, 0, 2, 4'b1111, 4'b0000, labs(0,0,0,0), 4'b0000, 0, 0);
      chk("R2 no request no grant", gnt_valid, 0);
      step(1, 1, 0, 2, 4'b0000, 4'b0000, labs(0,0,0,0), 4'b0000, 0, 0);
      chk("R2 empty candidates no grant", gnt_valid, 0);
      chk("R2 empty candidates no label", lbl_set_en, 0);
   endtask

   task automatic t_release();
      step(1, 0, 0, 0, 4'b0001, 4'b0000, labs(0,0,0,0), 4'b0000, 1, 2);
      chk("R9 clear issued", lbl_clr_en, 1);
      chk("R9 clear dim", lbl_clr_dim, 2);
      chk("R9 concurrent grant", gnt_valid, 1);
      step(0, 0, 0, 0, 4'b0000, 4'b0000, labs(0,0,0,0), 4'b0000, 0, 0);
      chk("R9 clear is one cycle", lbl_clr_en, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_free_reversal();
      t_free_skip_busy();
      t_wait_label();
      t_escape();
      t_sticky();
      t_saturation();
      t_idle();
      t_release();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule